// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a 32-bit timer that counts down and is driven through a small register window. Software sets a start value and a clock divider, and picks single-run or repeating operation. When the running count steps from one to zero, the block latches a pending flag. The flag drives a level interrupt until software clears it by writing a one.

The divider is an 8-bit field P. One decrement happens every P+1 clock cycles. The divider phase restarts at zero whenever software writes the count, writes the start value, or turns counting on, so the first step after any of these always takes the full P+1 cycles. The register port has a byte address, a write strobe, write data and combinational read data. Each register is one 32-bit word, and address bits 1:0 are ignored.

Top module: `pdt_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `tmr_irq` is low.
- R2: A write to the start-value word (offset 0x0) stores the value as both the start value and the current count, and restarts the divider phase. Reading offset 0x0 returns the stored start value.
- R3: The control word is at offset 0x8. Bit 0 is enable, bit 1 is repeat mode, and bits 15:8 are the divider P. All other control bits read as zero.
- R4: A write to the count word (offset 0x4) replaces the current count and restarts the divider phase.
- R5: While the timer is enabled and the count is nonzero, the count decreases by one every P+1 cycles. The first decrement comes P+1 cycles after the restart.
- R6: In single-run mode (bit 1 clear), when the count steps from one to zero the pending flag is set. The count then stays at zero and counting stops.
- R7: In repeat mode, when the count steps from one to zero the pending flag is set and the count is refilled from the start value in the same cycle. Counting then continues.
- R8: Reading the count word returns zero while enable is clear or the count is zero. The stored count holds its value while the timer is disabled.
- R9: When enable goes from 0 to 1 with a zero count and repeat mode is selected in the same write, the count is first loaded from the start value.
- R10: The pending flag is at offset 0xC, bit 0. Writing a one to bit 0 clears it, and writing a zero has no effect. `tmr_irq` equals the flag. If an expiry and a clear happen in the same cycle, the flag is set.
- R11: A zero count never produces an expiry, even while the timer is enabled.
- R12: Word offsets 0x10 to 0x1C read as zero and ignore writes.
- R13: A write to the count or start value that lands in the same cycle as a decrement takes precedence over the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Byte address within the 32-byte window |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| tmr_irq | output | 1 | Level interrupt, equal to the pending flag |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, an 8-bit divider and a 5-bit address. This covers the full four-word window plus the unmapped upper half. Divider values of 0, 2 and 3 keep every expiry within tens of cycles, so the exact timing of the first decrement, a refill, and a clear landing on an expiry can all be checked directly. Using P = 0 makes every enabled cycle a decrement cycle, so any count write also collides with a step.

// File: rtl/pdt_pkg.sv
// Package: shared field positions and word indices for the down-counting timer.
// Assumes registers are 32-bit words selected by address bits above bit 1.
package pdt_pkg;
    localparam int PDT_EN_BIT    = 0;
    localparam int PDT_AUTO_BIT  = 1;
    localparam int PDT_PRE_LSB   = 8;
    localparam int PDT_CLR_BIT   = 0;
    localparam int PDT_WORD_LOAD = 0;
    localparam int PDT_WORD_CNT  = 1;
    localparam int PDT_WORD_CTRL = 2;
    localparam int PDT_WORD_STAT = 3;
endpackage

// File: rtl/pdt_prescale.sv
// Module: pdt_prescale
// Purpose: divides the clock by DIV+1 into single-cycle step pulses while running.
// Assumes: restart forces the phase to zero, so the next step is a full period away.
module pdt_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] div,
    output logic             step
);
    logic [PRE_W-1:0] phase_q;

    assign step = run && (phase_q >= div);

    // Phase counter: cleared on restart or step, advances while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= step ? '0 : phase_q + PRE_W'(1);
        end
    end

    // R5
    step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (!step || div == '0));
endmodule

// File: rtl/pdt_ctrl.sv
// Module: pdt_ctrl
// Purpose: holds the control fields and the pending flag; detects the enable edge.
// Assumes: expiry and a clear in the same cycle leave the flag set.
module pdt_ctrl #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             stat_wr,
    input  logic             wr_en,
    input  logic             wr_auto,
    input  logic [PRE_W-1:0] wr_div,
    input  logic             wr_clr,
    input  logic             expire,
    output logic             en,
    output logic             auto_rl,
    output logic [PRE_W-1:0] div,
    output logic             en_rise,
    output logic             pending
);
    assign en_rise = ctrl_wr && !en && wr_en;

    // Control fields: replaced whole on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            auto_rl <= 1'b0;
            div     <= '0;
        end else if (ctrl_wr) begin
            en      <= wr_en;
            auto_rl <= wr_auto;
            div     <= wr_div;
        end
    end

    // Pending flag: set by expiry, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (expire) begin
            pending <= 1'b1;
        end else if (stat_wr && wr_clr) begin
            pending <= 1'b0;
        end
    end

    // R10
    pend_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(stat_wr && wr_clr));
endmodule

// File: rtl/pdt_count.sv
// Module: pdt_count
// Purpose: stores the start value and the running count, and reports expiry.
// Assumes: count/start writes win over a step in the same cycle; en_rise never
//          coincides with step because the timer was disabled.
module pdt_count #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_wr,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              en_rise,
    input  logic              rise_auto,
    input  logic              auto_rl,
    input  logic              step,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] start_val,
    output logic              expire
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic last_step;

    assign last_step = (count == ONE);
    assign expire    = step && last_step && !load_wr && !cnt_wr;

    // Start value register: written only through its own word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_val <= '0;
        end else if (load_wr) begin
            start_val <= wdata;
        end
    end

    // Running count: writes, then enable refill, then decrement or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_wr || cnt_wr) begin
            count <= wdata;
        end else if (en_rise && rise_auto && count == '0) begin
            count <= start_val;
        end else if (step) begin
            if (last_step) begin
                count <= auto_rl ? start_val : '0;
            end else begin
                count <= count - ONE;
            end
        end
    end

    // R6
    oneshot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !auto_rl |=> count == '0);
    // R7
    refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire && auto_rl |=> count == $past(start_val));
    // R5
    dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load_wr && !cnt_wr && count > ONE |=> count == $past(count) - ONE);
endmodule

// File: rtl/pdt_timer.sv
// Module: pdt_timer (top)
// Purpose: register window decode, read mux and wiring of divider, control and count.
// Assumes: one write per cycle; address bits 1:0 ignored; unmapped words read zero.
module pdt_timer #(
    parameter int DATA_W = 32,
    parameter int PRE_W  = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tmr_irq
);
    import pdt_pkg::*;

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              unused_addr_lsb;
    logic              hit_load, hit_cnt, hit_ctrl, hit_stat;
    logic              load_wr, cnt_wr, ctrl_wr, stat_wr;
    logic              en, auto_rl, en_rise, pending, step, expire, run;
    logic [PRE_W-1:0]  div;
    logic [DATA_W-1:0] count, start_val, ctrl_view;

    assign word            = reg_addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^reg_addr[1:0];

    assign hit_load = (word == WORD_W'(PDT_WORD_LOAD));
    assign hit_cnt  = (word == WORD_W'(PDT_WORD_CNT));
    assign hit_ctrl = (word == WORD_W'(PDT_WORD_CTRL));
    assign hit_stat = (word == WORD_W'(PDT_WORD_STAT));

    assign load_wr = reg_we && hit_load;
    assign cnt_wr  = reg_we && hit_cnt;
    assign ctrl_wr = reg_we && hit_ctrl;
    assign stat_wr = reg_we && hit_stat;

    assign run     = en && (count != '0);
    assign tmr_irq = pending;

    pdt_prescale #(.PRE_W(PRE_W)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (load_wr || cnt_wr || en_rise),
        .div     (div),
        .step    (step)
    );

    pdt_ctrl #(.PRE_W(PRE_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .stat_wr (stat_wr),
        .wr_en   (reg_wdata[PDT_EN_BIT]),
        .wr_auto (reg_wdata[PDT_AUTO_BIT]),
        .wr_div  (reg_wdata[PDT_PRE_LSB +: PRE_W]),
        .wr_clr  (reg_wdata[PDT_CLR_BIT]),
        .expire  (expire),
        .en      (en),
        .auto_rl (auto_rl),
        .div     (div),
        .en_rise (en_rise),
        .pending (pending)
    );

    pdt_count #(.DATA_W(DATA_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_wr   (load_wr),
        .cnt_wr    (cnt_wr),
        .wdata     (reg_wdata),
        .en_rise   (en_rise),
        .rise_auto (reg_wdata[PDT_AUTO_BIT]),
        .auto_rl   (auto_rl),
        .step      (step),
        .count     (count),
        .start_val (start_val),
        .expire    (expire)
    );

    // Control word view: only the defined fields, other bits zero.
    always_comb begin
        ctrl_view                         = '0;
        ctrl_view[PDT_EN_BIT]             = en;
        ctrl_view[PDT_AUTO_BIT]           = auto_rl;
        ctrl_view[PDT_PRE_LSB +: PRE_W]   = div;
    end

    // Read mux: selects the addressed word, zero for unmapped offsets.
    always_comb begin
        reg_rdata = '0;
        if (hit_load) begin
            reg_rdata = start_val;
        end else if (hit_cnt) begin
            reg_rdata = run ? count : '0;
        end else if (hit_ctrl) begin
            reg_rdata = ctrl_view;
        end else if (hit_stat) begin
            reg_rdata[PDT_CLR_BIT] = pending;
        end
    end

    // R11
    expiry_from_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_irq) |-> $past(count) == DATA_W'(1));
    // R8
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == $past(count)) || $past(load_wr || cnt_wr || en_rise));
endmodule

// File: tb/test_pdt_timer.sv
`timescale 1ns/1ps
module test_pdt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // Behavioural reference state
    logic [31:0] m_load = '0, m_cnt = '0, m_ncnt;
    bit          m_en = 0, m_auto = 0, m_stat = 0, m_exp;
    int          m_pre = 0, m_wait = 0, m_nwait;

    always #2.5 clk = ~clk;

    pdt_timer i_pdt_timer (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we),
        .reg_wdata(wd), .reg_rdata(rd), .tmr_irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(logic [4:0] a);
        case (a[4:2])
            3'd0: return m_load;
            3'd1: return (m_en && m_cnt != 0) ? m_cnt : 32'h0;
            3'd2: return {16'h0, 8'(m_pre), 6'h0, m_auto, m_en};
            3'd3: return {31'h0, m_stat};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [4:0] a);
        case (a[4:2])
            3'd0: return "R2";
            3'd1: return "R4";
            3'd2: return "R3";
            3'd3: return "R10";
            default: return "R12";
        endcase
    endfunction

    // Reference model: advances one clock using the inputs seen at the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_load = 0; m_cnt = 0; m_en = 0; m_auto = 0; m_stat = 0; m_pre = 0; m_wait = 0;
            started = 1;
        end else begin
            m_ncnt = m_cnt; m_nwait = m_wait; m_exp = 0;
            if (m_en && m_cnt != 0) begin
                if (m_wait == 0) begin
                    m_nwait = m_pre;
                    if (m_cnt == 1) begin
                        m_exp = 1;
                        m_ncnt = m_auto ? m_load : 32'h0;
                    end else m_ncnt = m_cnt - 1;
                end else m_nwait = m_wait - 1;
            end
            if (we) begin
                case (addr[4:2])
                    3'd0: begin m_load = wd; m_ncnt = wd; m_nwait = m_pre; m_exp = 0; end
                    3'd1: begin m_ncnt = wd; m_nwait = m_pre; m_exp = 0; end
                    3'd2: begin
                        if (!m_en && wd[0]) begin
                            if (m_cnt == 0 && wd[1]) m_ncnt = m_load;
                            m_nwait = int'(wd[15:8]);
                        end
                        m_en = wd[0]; m_auto = wd[1]; m_pre = int'(wd[15:8]);
                    end
                    3'd3: if (wd[0]) m_stat = 0;
                    default: ;
                endcase
            end
            if (m_exp) m_stat = 1;
            m_cnt = m_ncnt; m_wait = m_nwait;
        end
    end

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started && rst_n && !done) begin
            chk(tag_of(addr), rd, model_rd(addr), "read vs model");
            chk("R10", {31'h0, irq}, {31'h0, m_stat}, "irq vs model");
        end
    end

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(posedge clk); #1;
        addr = a; wd = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic peek(logic [4:0] a, logic [31:0] exp, string req);
        addr = a; #1;
        chk(req, rd, exp, "directed read");
    endtask

    task automatic cycles_to_irq(int exp, string req);
        int n = 0;
        while (!irq && n < 60) begin
            @(posedge clk); #1;
            n++;
        end
        chk(req, n, exp, "cycles to expiry");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        peek(5'h00, 0, "R1"); peek(5'h04, 0, "R1");
        peek(5'h08, 0, "R1"); peek(5'h0C, 0, "R1");
        chk("R1", {31'h0, irq}, 0, "irq after reset");

        // R3: only defined control fields stored
        wr(5'h08, 32'hFFFF_FFFC);
        peek(5'h08, 32'h0000_FF00, "R3");

        // R5/R6: single run, P=2, count 3 -> 9 cycles
        wr(5'h08, 32'h0000_0200);
        wr(5'h00, 3);
        peek(5'h04, 0, "R8");
        wr(5'h08, 32'h0000_0201);
        cycles_to_irq(9, "R5");
        peek(5'h04, 0, "R6");
        repeat (10) @(posedge clk); #1;
        chk("R6", {31'h0, irq}, 1, "flag stays after stop");
        peek(5'h04, 0, "R6");

        // R10: zero write no effect, one clears
        wr(5'h0C, 0);
        chk("R10", {31'h0, irq}, 1, "write zero keeps flag");
        wr(5'h0C, 1);
        chk("R10", {31'h0, irq}, 0, "write one clears flag");

        // R9/R7: repeat, P=0, start 4, enable from zero count
        wr(5'h08, 0);
        wr(5'h00, 4);
        wr(5'h04, 0);
        wr(5'h08, 32'h0000_0003);
        peek(5'h04, 4, "R9");
        cycles_to_irq(4, "R7");
        peek(5'h04, 4, "R7");
        wr(5'h0C, 1);
        wr(5'h0C, 1);
        chk("R10", {31'h0, irq}, 1, "expiry wins over clear");

        // R4/R13/R2: writes colliding with steps
        wr(5'h04, 10);
        peek(5'h04, 10, "R13");
        wr(5'h00, 7);
        peek(5'h04, 7, "R2");
        peek(5'h00, 7, "R2");
        repeat (20) @(posedge clk); #1;

        // R8: count held while disabled
        wr(5'h08, 0);
        wr(5'h04, 5);
        peek(5'h04, 0, "R8");
        repeat (5) @(posedge clk); #1;
        wr(5'h08, 1);
        peek(5'h04, 5, "R8");
        repeat (12) @(posedge clk); #1;

        // R11: zero count enabled never expires
        wr(5'h08, 0);
        wr(5'h04, 0);
        wr(5'h0C, 1);
        wr(5'h08, 1);
        repeat (20) @(posedge clk); #1;
        chk("R11", {31'h0, irq}, 0, "no expiry at zero");

        // R12: unmapped words and ignored low address bits
        wr(5'h08, 0);
        wr(5'h00, 32'h1234);
        peek(5'h02, 32'h1234, "R12");
        wr(5'h14, 32'hFFFF_FFFF);
        peek(5'h14, 0, "R12");
        peek(5'h00, 32'h1234, "R12");
        peek(5'h08, 0, "R12");

        // Mixed run: repeat mode, P=3, start 5, with periodic clears
        wr(5'h00, 5);
        wr(5'h08, 32'h0000_0303);
        for (int k = 0; k < 8; k++) begin
            repeat (9) @(posedge clk); #1;
            wr(5'h0C, 1);
        end
        wr(5'h08, 32'h0000_0301);
        repeat (40) @(posedge clk); #1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule